// File: doc/BRIEF.md
# Set-Associative Data Cache Controller

This block sits between a processor load/store port and a slower memory port. It keeps recently used 32-byte lines in a four-way set-associative store. Each request carries its own attributes: whether the region may be cached, whether a store hit is held in the cache (write-back) or also sent to memory (write-through), and whether a store miss brings the line in first. A load that misses always brings the line in before it answers.

Each processor request moves two 32-bit words: the word at the given word address and the word after it. When the first word is the last word of a line, the pair spans two lines, so the two words are served as two separate line operations. Line transfers to and from memory are eight-beat bursts that start on a line boundary. Uncached loads and stores, and the memory copy of a write-through store, use single-word transfers. A flush command writes every dirty line back, invalidates the whole store, and then raises a one-cycle done pulse.

The default geometry has four sets so that it can be swept quickly. With `SETS` set to 256 the store holds 32 KB in 1024 lines.

Top module: `dcache_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `cpu_ack`, `flush_done` and `mem_req` are low. Every line is invalid, so the first load of any address produces a line fill.
- R2: A cacheable load miss reads exactly eight beats from memory. The beats run in ascending word order from the 32-byte-aligned base of the line, whatever word was asked for. A repeated load of the same words causes no memory traffic.
- R3: A request whose first word is word 7 of a line causes two line fills, first the lower line and then the next one.
- R4: A write-back store hit changes only the cached line and causes no memory traffic. The merged bytes are written to memory only when that line is evicted or flushed.
- R5: A write-through store hit updates the cached line and issues one single-word memory write per word. Each write carries that word's byte enables. No burst is issued.
- R6: A store miss with allocate set first fills the line, then applies the write policy of the request. A store miss without allocate issues single-word writes only, and a later load of that line still misses.
- R7: A non-cacheable access performs one single-word memory transfer per word. It never issues a burst and never leaves the data in the cache, so repeating it repeats the memory traffic.
- R8: On a miss the victim is the lowest-numbered invalid way of the set. If no way is invalid, the victim is the way held in that set's round-robin pointer. The pointer starts at 0 and becomes the way after the one just filled, modulo 4.
- R9: A dirty victim is written back as a complete eight-beat burst before the first beat of the replacing fill.
- R10: A flush writes back every dirty line as one burst each and leaves every line invalid. It raises `flush_done` for exactly one cycle at the end.
- R11: Each request is answered by a one-cycle `cpu_ack`. On a load, `cpu_rdata[31:0]` holds the word at `cpu_addr` and `cpu_rdata[63:32]` holds the next word. Byte enable bit k of `cpu_be` selects byte k of `cpu_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request strobe, sampled while idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW-2 | Word address of the first word |
| cpu_wdata | input | 64 | Store data for two words |
| cpu_be | input | 8 | Byte enables for the store data |
| cpu_cacheable | input | 1 | Region may be cached |
| cpu_write_back | input | 1 | 1 = write-back, 0 = write-through |
| cpu_write_alloc | input | 1 | Store miss allocates the line |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 64 | Load data, valid with `cpu_ack` |
| flush_req | input | 1 | Start clean-and-invalidate, sampled while idle |
| flush_done | output | 1 | One-cycle pulse when the flush ends |
| mem_req | output | 1 | Memory transfer active; held until the last beat |
| mem_we | output | 1 | Memory write |
| mem_burst | output | 1 | 1 = eight-beat line burst, 0 = single word |
| mem_addr | output | AW-2 | Word address of the current beat |
| mem_wdata | output | 32 | Write data of the current beat |
| mem_be | output | 4 | Byte enables of the current beat |
| mem_ack | input | 1 | The current beat completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
Loads are swept across all eight word offsets of a line from a cold cache. The count of fill bursts and their base addresses separate a single-line access from a straddling one, and an immediate repeat separates a hit from a miss. Stores are tried under every mix of write-back or write-through and allocate or not, on hits and on misses. The bench compares memory content and the counts of burst and single-word transfers, which tells apart where each policy puts the data. A sequence of five tags in one set, with one dirty line, shows the invalid-first then round-robin victim order and the write-back-before-fill order. Flushes with several dirty lines check the write-back count, the single done pulse, and that every line misses afterwards.

// File: rtl/dcache_pkg.sv
// Shared types of the data cache controller.
// Assumes nothing beyond IEEE 1800-2017.
package dcache_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOK,
        S_EVICT,
        S_FILL,
        S_SINGLE,
        S_SWEEP,
        S_SWB
    } dc_state_t;

endpackage

// File: rtl/dcache_victim_sel.sv
// Victim way choice for one set: the lowest invalid way, otherwise the
// round-robin pointer of the set. Purely combinational.
// Assumes WAYS is a power of two, at least 2.
module dcache_victim_sel #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  set_valid,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] victim
);

    // Scan from the top so that the lowest invalid way wins
    always_comb begin
        victim = rr_ptr;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) victim = WAY_W'(w);
        end
    end

endmodule

// File: rtl/dcache_byte_merge.sv
// Byte-wise merge of store data into a 32-bit word under byte enables.
// Assumes byte k of the word is bits [8k+7:8k].
module dcache_byte_merge (
    input  logic [31:0] old_word,
    input  logic [31:0] new_word,
    input  logic [3:0]  byte_en,
    output logic [31:0] merged_word
);

    for (genvar b = 0; b < 4; b++) begin : g_lane
        // Pick the new byte where enabled
        assign merged_word[8*b +: 8] = byte_en[b] ? new_word[8*b +: 8] : old_word[8*b +: 8];
    end

endmodule

// File: rtl/dcache_ctrl.sv
// Set-associative data cache controller. Serves two-word requests as two
// word operations, allocates on every cacheable load miss, applies the
// per-request write policy, writes dirty victims back before filling, and
// runs a whole-store clean-and-invalidate on request.
// Assumes WAYS, SETS and LINE_BYTES are powers of two (WAYS, SETS >= 2,
// LINE_BYTES >= 8), and the memory holds mem_req with its fields stable until
// it acknowledges the beat.
module dcache_ctrl
    import dcache_pkg::*;
#(
    parameter int AW         = 16,
    parameter int WAYS       = 4,
    parameter int SETS       = 4,
    parameter int LINE_BYTES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:2] cpu_addr,
    input  logic [63:0]   cpu_wdata,
    input  logic [7:0]    cpu_be,
    input  logic          cpu_cacheable,
    input  logic          cpu_write_back,
    input  logic          cpu_write_alloc,
    output logic          cpu_ack,
    output logic [63:0]   cpu_rdata,
    input  logic          flush_req,
    output logic          flush_done,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_burst,
    output logic [AW-1:2] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata
);

    localparam int WPL    = LINE_BYTES / 4;
    localparam int OFF_W  = $clog2(WPL);
    localparam int BOFF   = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LIDX_W = SET_W + WAY_W;
    localparam int NLINES = SETS * WAYS;
    localparam int TAG_W  = AW - BOFF - SET_W;

    dc_state_t          st;
    logic               half_q, we_q, c_q, wb_q, wa_q, ack_q, done_q;
    logic [AW-1:2]      addr_q;
    logic [63:0]        wdata_q, rdata_q;
    logic [7:0]         be_q;
    logic [OFF_W-1:0]   beat_q;
    logic [WAY_W-1:0]   vic_q;
    logic [LIDX_W-1:0]  sweep_q;
    logic [NLINES-1:0]  valid_q, dirty_q;
    logic [TAG_W-1:0]   tag_q  [NLINES];
    logic [31:0]        data_q [NLINES*WPL];
    logic [WAY_W-1:0]   rr_q   [SETS];

    logic [AW-1:2]      cur;
    logic [SET_W-1:0]   cur_set;
    logic [TAG_W-1:0]   cur_tag;
    logic [OFF_W-1:0]   cur_wd;
    logic [31:0]        sub_wd, hit_word, merged;
    logic [3:0]         sub_be;
    logic               hit, sub_done, last_beat;
    logic [WAY_W-1:0]   hit_way, vic_way;
    logic [LIDX_W-1:0]  hline, vline, nline;
    logic [WAYS-1:0]    set_valid;

    // Address of the word being served and its fields
    assign cur       = addr_q + (AW-2)'(half_q);
    assign cur_set   = cur[BOFF +: SET_W];
    assign cur_tag   = cur[AW-1 -: TAG_W];
    assign cur_wd    = cur[2 +: OFF_W];
    assign sub_wd    = half_q ? wdata_q[63:32] : wdata_q[31:0];
    assign sub_be    = half_q ? be_q[7:4] : be_q[3:0];
    assign hline     = {cur_set, hit_way};
    assign vline     = {cur_set, vic_q};
    assign nline     = {cur_set, vic_way};
    assign set_valid = valid_q[{cur_set, {WAY_W{1'b0}}} +: WAYS];
    assign hit_word  = data_q[{hline, cur_wd}];
    assign last_beat = (beat_q == OFF_W'(WPL - 1));
    assign cpu_ack   = ack_q;
    assign cpu_rdata = rdata_q;
    assign flush_done = done_q;

    // Tag compare across the ways of the addressed set
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_q[{cur_set, WAY_W'(w)}] && tag_q[{cur_set, WAY_W'(w)}] == cur_tag) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    dcache_byte_merge u_merge (
        .old_word    (hit_word),
        .new_word    (sub_wd),
        .byte_en     (sub_be),
        .merged_word (merged)
    );

    dcache_victim_sel #(.WAYS(WAYS)) u_victim (
        .set_valid (set_valid),
        .rr_ptr    (rr_q[cur_set]),
        .victim    (vic_way)
    );

    // A word operation finishes on a hit that needs no memory, or a single beat
    assign sub_done = (st == S_LOOK && c_q && hit && (!we_q || wb_q)) ||
                      (st == S_SINGLE && mem_ack);

    // Memory port drive per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_burst = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        unique case (st)
            S_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = {tag_q[vline], cur_set, beat_q};
                mem_wdata = data_q[{vline, beat_q}];
                mem_be    = 4'hF;
            end
            S_FILL: begin
                mem_req   = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = {cur_tag, cur_set, beat_q};
            end
            S_SINGLE: begin
                mem_req   = 1'b1;
                mem_we    = we_q;
                mem_addr  = cur;
                mem_wdata = sub_wd;
                mem_be    = we_q ? sub_be : 4'hF;
            end
            S_SWB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = {tag_q[sweep_q], sweep_q[LIDX_W-1 -: SET_W], beat_q};
                mem_wdata = data_q[{sweep_q, beat_q}];
                mem_be    = 4'hF;
            end
            default: ;
        endcase
    end

    // Sequencer, line state and data store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            valid_q <= '0;
            dirty_q <= '0;
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
            ack_q   <= 1'b0;
            done_q  <= 1'b0;
            half_q  <= 1'b0;
            beat_q  <= '0;
            vic_q   <= '0;
            sweep_q <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            be_q    <= '0;
            {we_q, c_q, wb_q, wa_q} <= '0;
        end else begin
            ack_q  <= 1'b0;
            done_q <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (flush_req) begin
                        sweep_q <= '0;
                        st      <= S_SWEEP;
                    end else if (cpu_req) begin
                        half_q  <= 1'b0;
                        addr_q  <= cpu_addr;
                        we_q    <= cpu_we;
                        wdata_q <= cpu_wdata;
                        be_q    <= cpu_be;
                        c_q     <= cpu_cacheable;
                        wb_q    <= cpu_write_back;
                        wa_q    <= cpu_write_alloc;
                        st      <= S_LOOK;
                    end
                end
                S_LOOK: begin
                    if (!c_q) begin
                        st <= S_SINGLE;
                    end else if (hit) begin
                        if (!we_q) begin
                            if (half_q) rdata_q[63:32] <= hit_word;
                            else        rdata_q[31:0]  <= hit_word;
                        end else begin
                            data_q[{hline, cur_wd}] <= merged;
                            if (wb_q) dirty_q[hline] <= 1'b1;
                            else      st <= S_SINGLE;
                        end
                    end else if (!we_q || wa_q) begin
                        vic_q  <= vic_way;
                        beat_q <= '0;
                        st     <= (valid_q[nline] && dirty_q[nline]) ? S_EVICT : S_FILL;
                    end else begin
                        st <= S_SINGLE;
                    end
                end
                S_EVICT: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + OFF_W'(1);
                        if (last_beat) begin
                            valid_q[vline] <= 1'b0;
                            dirty_q[vline] <= 1'b0;
                            st <= S_FILL;
                        end
                    end
                end
                S_FILL: begin
                    if (mem_ack) begin
                        data_q[{vline, beat_q}] <= mem_rdata;
                        beat_q <= beat_q + OFF_W'(1);
                        if (last_beat) begin
                            valid_q[vline] <= 1'b1;
                            dirty_q[vline] <= 1'b0;
                            tag_q[vline]   <= cur_tag;
                            rr_q[cur_set]  <= vic_q + WAY_W'(1);
                            st <= S_LOOK;
                        end
                    end
                end
                S_SINGLE: begin
                    if (mem_ack && !we_q) begin
                        if (half_q) rdata_q[63:32] <= mem_rdata;
                        else        rdata_q[31:0]  <= mem_rdata;
                    end
                end
                S_SWEEP: begin
                    if (valid_q[sweep_q] && dirty_q[sweep_q]) begin
                        beat_q <= '0;
                        st     <= S_SWB;
                    end else begin
                        valid_q[sweep_q] <= 1'b0;
                        dirty_q[sweep_q] <= 1'b0;
                        if (sweep_q == LIDX_W'(NLINES - 1)) begin
                            done_q <= 1'b1;
                            st     <= S_IDLE;
                        end else begin
                            sweep_q <= sweep_q + LIDX_W'(1);
                        end
                    end
                end
                S_SWB: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + OFF_W'(1);
                        if (last_beat) begin
                            dirty_q[sweep_q] <= 1'b0;
                            st <= S_SWEEP;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
            if (sub_done) begin
                if (!half_q) begin
                    half_q <= 1'b1;
                    st     <= S_LOOK;
                end else begin
                    ack_q <= 1'b1;
                    st    <= S_IDLE;
                end
            end
        end
    end

    // A burst opens on a line boundary
    assert_burst_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && mem_burst) |-> (mem_addr[BOFF-1:2] == '0));

    // A pending beat keeps its request and address until acknowledged
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // Uncached requests never read a line burst
    assert_no_uncached_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_burst && !mem_we) |-> c_q);

    // A fill into a set with a free way never lands on a valid line
    assert_invalid_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FILL && !(&set_valid)) |-> !valid_q[vline]);

    // A fill never overwrites a line still holding unwritten data
    assert_evict_before_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FILL) |-> !(valid_q[vline] && dirty_q[vline]));

    // The flush completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);

    // The request acknowledge is a single-cycle pulse
    assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

endmodule

// File: tb/dcache_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a word memory model with traffic counters and a
// golden image of what loads must return.
module dcache_ctrl_tb_top;

    localparam int AW = 16;
    localparam int MW = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:2] cpu_addr = '0;
    logic [63:0]   cpu_wdata = '0;
    logic [7:0]    cpu_be = '0;
    logic          cpu_cacheable = 1'b0, cpu_write_back = 1'b0, cpu_write_alloc = 1'b0;
    logic          cpu_ack, flush_done, mem_req, mem_we, mem_burst, mem_ack;
    logic          flush_req = 1'b0;
    logic [63:0]   cpu_rdata;
    logic [AW-1:2] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic [3:0]    mem_be;

    always #2 clk = ~clk;

    dcache_ctrl #(.AW(AW), .WAYS(4), .SETS(4), .LINE_BYTES(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_cacheable(cpu_cacheable), .cpu_write_back(cpu_write_back),
        .cpu_write_alloc(cpu_write_alloc), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .flush_req(flush_req), .flush_done(flush_done), .mem_req(mem_req),
        .mem_we(mem_we), .mem_burst(mem_burst), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [31:0] mem  [MW];
    logic [31:0] gold [MW];
    logic [16:0] logq [256];
    int rbeats = 0, wbeats = 0, sreads = 0, swrites = 0, nlog = 0, dones = 0;
    int n_chk = 0, n_bad = 0;
    int s_rb, s_wb, s_sr, s_sw, s_dn, s_log;

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[11:2]];

    // Memory model and traffic monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (flush_done) dones++;
            if (mem_req && mem_ack) begin
                if (mem_burst && mem_addr[4:2] == 3'd0) begin
                    logq[nlog % 256] = {mem_we, mem_addr, 2'b00};
                    nlog++;
                end
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] = mem_wdata[8*b +: 8];
                    if (mem_burst) wbeats++; else swrites++;
                end else begin
                    if (mem_burst) rbeats++; else sreads++;
                end
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic snap();
        s_rb = rbeats; s_wb = wbeats; s_sr = sreads; s_sw = swrites; s_dn = dones; s_log = nlog;
    endtask

    function automatic logic [63:0] gold2(input int a);
        return {gold[((a >> 2) + 1) % MW], gold[(a >> 2) % MW]};
    endfunction

    function automatic logic [63:0] mem2(input int a);
        return {mem[((a >> 2) + 1) % MW], mem[(a >> 2) % MW]};
    endfunction

    task automatic access(input bit we, input int a, input logic [63:0] wd, input logic [7:0] be,
                          input bit c, input bit wbk, input bit wal, output logic [63:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = 14'(a >> 2); cpu_wdata = wd; cpu_be = be;
        cpu_cacheable = c; cpu_write_back = wbk; cpu_write_alloc = wal;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_ack) @(negedge clk);
        rd = cpu_rdata;
        if (we)
            for (int i = 0; i < 2; i++)
                for (int b = 0; b < 4; b++)
                    if (be[4*i+b]) gold[((a >> 2) + i) % MW][8*b +: 8] = wd[32*i + 8*b +: 8];
    endtask

    task automatic load(input string req, input int a, input bit c);
        logic [63:0] rd;
        access(1'b0, a, '0, '0, c, 1'b1, 1'b1, rd);
        check(req, rd, gold2(a));
    endtask

    task automatic store(input int a, input logic [63:0] wd, input logic [7:0] be,
                         input bit c, input bit wbk, input bit wal);
        logic [63:0] rd;
        access(1'b1, a, wd, be, c, wbk, wal, rd);
    endtask

    task automatic flush();
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        while (!flush_done) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int traffic();
        return (rbeats - s_rb) + (wbeats - s_wb) + (sreads - s_sr) + (swrites - s_sw);
    endfunction

    // Watchdog: a hung run is counted as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] pre;
        for (int i = 0; i < MW; i++) begin
            mem[i]  = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
            gold[i] = mem[i];
        end
        repeat (4) @(negedge clk);
        check("R1 ack in reset", 64'(cpu_ack), 64'd0);
        check("R1 mem_req in reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack after reset", 64'(cpu_ack), 64'd0);
        check("R1 mem_req after reset", 64'(mem_req), 64'd0);
        check("R1 flush_done after reset", 64'(flush_done), 64'd0);

        // R2 / R3 / R11: offset sweep over one line from a cold store
        for (int off = 0; off < 8; off++) begin
            if (off != 0) flush();
            snap();
            load("R11 load data", 32'h100 + off * 4, 1'b1);
            check("R3 fill beats", 64'(rbeats - s_rb), (off == 7) ? 64'd16 : 64'd8);
            check("R2 fill base", 64'(logq[s_log % 256]), {47'd0, 1'b0, 16'h0100});
            if (off == 7) check("R3 second fill base", 64'(logq[(s_log + 1) % 256]), {47'd0, 1'b0, 16'h0120});
            if (off == 0) check("R1 cold miss", 64'(rbeats - s_rb), 64'd8);
            snap();
            load("R2 hit data", 32'h100 + off * 4, 1'b1);
            check("R2 hit traffic", 64'(traffic()), 64'd0);
        end

        // R4: write-back hit stays in the line until flushed
        flush();
        load("R2 load", 32'h200, 1'b1);
        snap();
        pre = mem2(32'h200);
        store(32'h200, 64'hDEADBEEF_CAFEF00D, 8'h96, 1'b1, 1'b1, 1'b1);
        check("R4 hit traffic", 64'(traffic()), 64'd0);
        check("R4 memory untouched", mem2(32'h200), pre);
        load("R4 merged data", 32'h200, 1'b1);
        snap();
        flush();
        check("R10 writeback beats", 64'(wbeats - s_wb), 64'd8);
        check("R4 writeback base", 64'(logq[s_log % 256]), {47'd0, 1'b1, 16'h0200});
        check("R4 memory after flush", mem2(32'h200), gold2(32'h200));
        check("R10 done pulses", 64'(dones - s_dn), 64'd1);

        // R5: write-through hit
        load("R2 load", 32'h240, 1'b1);
        snap();
        store(32'h244, 64'h01234567_89ABCDEF, 8'hFF, 1'b1, 1'b0, 1'b1);
        check("R5 single writes", 64'(swrites - s_sw), 64'd2);
        check("R5 no bursts", 64'((rbeats - s_rb) + (wbeats - s_wb)), 64'd0);
        check("R5 memory updated", mem2(32'h244), gold2(32'h244));
        snap();
        load("R5 line updated", 32'h244, 1'b1);
        check("R5 hit traffic", 64'(traffic()), 64'd0);

        // R6: store miss without allocate, then with allocate
        flush();
        snap();
        store(32'h300, 64'h11112222_33334444, 8'hFF, 1'b1, 1'b0, 1'b0);
        check("R6 no-alloc single writes", 64'(swrites - s_sw), 64'd2);
        check("R6 no-alloc no fill", 64'(rbeats - s_rb), 64'd0);
        check("R6 no-alloc memory", mem2(32'h300), gold2(32'h300));
        snap();
        load("R6 no-alloc load", 32'h300, 1'b1);
        check("R6 not allocated", 64'(rbeats - s_rb), 64'd8);
        flush();
        snap();
        pre = mem2(32'h340);
        store(32'h340, 64'hA1B2C3D4_E5F60718, 8'h3C, 1'b1, 1'b1, 1'b1);
        check("R6 alloc fill", 64'(rbeats - s_rb), 64'd8);
        check("R6 alloc no single", 64'(swrites - s_sw), 64'd0);
        check("R6 alloc memory untouched", mem2(32'h340), pre);
        snap();
        load("R6 alloc data", 32'h340, 1'b1);
        check("R6 alloc hit", 64'(traffic()), 64'd0);

        // R7: uncached accesses go to memory every time
        flush();
        snap();
        load("R7 uncached data", 32'h380, 1'b0);
        check("R7 single reads", 64'(sreads - s_sr), 64'd2);
        check("R7 no burst", 64'(rbeats - s_rb), 64'd0);
        snap();
        load("R7 uncached repeat", 32'h380, 1'b0);
        check("R7 repeat reads", 64'(sreads - s_sr), 64'd2);
        snap();
        store(32'h388, 64'h55AA55AA_0F0F0F0F, 8'hFF, 1'b0, 1'b1, 1'b1);
        check("R7 single writes", 64'(swrites - s_sw), 64'd2);
        check("R7 memory updated", mem2(32'h388), gold2(32'h388));

        // R8 / R9: five tags in set 0, one dirty line
        flush();
        snap();
        load("R8 fill", 32'h000, 1'b1);
        load("R8 fill", 32'h080, 1'b1);
        load("R8 fill", 32'h100, 1'b1);
        load("R8 fill", 32'h180, 1'b1);
        check("R8 four fills", 64'(rbeats - s_rb), 64'd32);
        store(32'h000, 64'h0BADF00D_FEEDFACE, 8'hFF, 1'b1, 1'b1, 1'b1);
        snap();
        load("R9 load", 32'h200, 1'b1);
        check("R9 writeback beats", 64'(wbeats - s_wb), 64'd8);
        check("R9 fill beats", 64'(rbeats - s_rb), 64'd8);
        check("R9 writeback first", 64'(logq[s_log % 256]), {47'd0, 1'b1, 16'h0000});
        check("R9 fill second", 64'(logq[(s_log + 1) % 256]), {47'd0, 1'b0, 16'h0200});
        check("R9 memory written", mem2(32'h000), gold2(32'h000));
        snap();
        load("R8 way1 kept", 32'h080, 1'b1);
        check("R8 way1 hit", 64'(traffic()), 64'd0);
        snap();
        load("R8 reload", 32'h000, 1'b1);
        check("R8 reload fill", 64'(rbeats - s_rb), 64'd8);
        snap();
        load("R8 way1 evicted", 32'h080, 1'b1);
        check("R8 way1 refill", 64'(rbeats - s_rb), 64'd8);
        snap();
        load("R8 way3 kept", 32'h180, 1'b1);
        check("R8 way3 hit", 64'(traffic()), 64'd0);

        // R10: flush with two dirty lines
        store(32'h000, 64'h12345678_9ABCDEF0, 8'hF0, 1'b1, 1'b1, 1'b1);
        store(32'h180, 64'hCAFED00D_BEEFCAFE, 8'h0F, 1'b1, 1'b1, 1'b1);
        snap();
        flush();
        check("R10 two writebacks", 64'(wbeats - s_wb), 64'd16);
        check("R10 one done pulse", 64'(dones - s_dn), 64'd1);
        check("R10 memory line 0", mem2(32'h000), gold2(32'h000));
        check("R10 memory line 3", mem2(32'h180), gold2(32'h180));
        snap();
        load("R10 after flush", 32'h180, 1'b1);
        check("R10 invalidated", 64'(rbeats - s_rb), 64'd8);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule